// File: doc/BRIEF.md
# Tone Transceiver Status and Interrupt Logic

This block keeps the four-bit status word of a telephone tone transceiver and drives its active-low interrupt request. Three sources feed it single-cycle event pulses. The transmitter signals that its inter-tone pause has ended. The receiver signals that a decoded digit has been latched. The steering detector signals that a tone has appeared or has gone away. A burst-mode level decides whether the transmit-ready flag may exist at all.

A host reads the status word over a narrow parallel bus. The bus has an active-low chip select, one register-select line, a read/write line and a data strobe. A status read returns the same value for the whole strobe. When the strobe ends, the read clears the event flags and releases the interrupt. The steering flag is different: it follows tone presence as a level, so reads do not clear it and it never requests an interrupt. An event that arrives in the same cycle as a read-triggered clear takes priority over the clear, so no event is lost.

Top module: `tone_status_irq`

## Requirements
- R1: After reset, status bits 0, 1 and 2 are 0, bit 3 is 1 (no tone present), and `irqN` is high.
- R2: A `evtDigitLatched` pulse sets status bit 2 (receive full) and bit 0 (interrupt pending) at the next clock edge, and `irqN` then goes low.
- R3: With `burstMode` high, an `evtPauseDone` pulse sets status bit 1 (transmit ready) and bit 0 at the next clock edge. With `burstMode` low, the same pulse changes no status bit and leaves `irqN` high.
- R4: While `burstMode` is low at a clock edge, status bit 1 is 0 after that edge.
- R5: A status read is a cycle with `csN` low, `regSel` high, `rdWrN` high and `dStrobe` high. During that cycle `busOe` is high and `busOut` carries the status word (bit n = status bit n). The value stays unchanged for as long as the strobe is high.
- R6: The clock edge that samples `dStrobe` low right after a status-read strobe clears status bits 0, 1 and 2, and `irqN` returns high.
- R7: If a set event arrives on the same edge as a read-triggered clear, the event's flag and bit 0 end up set.
- R8: `evtToneOff` alone sets bit 3, `evtToneOn` alone clears it, and both together leave it unchanged. Reads do not alter bit 3, and bit 3 never drives `irqN` low.
- R9: With `csN` high, `busOe` is low, and a strobe clears nothing.
- R10: A strobe with `regSel` low or `rdWrN` low clears nothing. A read with `regSel` low returns all zeros on `busOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| regSel | input | 1 | Register select; 1 selects the status word |
| rdWrN | input | 1 | 1 = read, 0 = write |
| dStrobe | input | 1 | Data strobe, active high |
| burstMode | input | 1 | Burst transmit mode enabled |
| evtPauseDone | input | 1 | Transmit pause ended (pulse) |
| evtDigitLatched | input | 1 | Receive digit latched (pulse) |
| evtToneOn | input | 1 | Valid tone detected (pulse) |
| evtToneOff | input | 1 | Valid tone absence detected (pulse) |
| busOut | output | DATA_W | Read data bus |
| busOe | output | 1 | Bus output enable (0 = high impedance) |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: a four-bit bus (`DATA_W = 4`) and a tone-absent reset state for the steering flag (`STEER_INIT = 1`). A four-bit bus makes the status word the whole bus. Each field position can therefore be checked directly, and a padding branch cannot hide a misplaced bit. The tone-absent reset value puts the steering flag at 1 from the start, so the bench can show it surviving a read and leaving the interrupt untouched before any tone event arrives.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Status bit positions, decoded by host software
  localparam int IRQ_BIT   = 0;
  localparam int TXRDY_BIT = 1;
  localparam int RXFUL_BIT = 2;
  localparam int STEER_BIT = 3;
  localparam int STAT_W    = 4;

  typedef struct packed {
    logic clearFlags;   // one-cycle pulse: strobe of a status read has ended
    logic driveStatus;  // current cycle is a read addressed to the status word
  } ctrl_strobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         regSel,
  input  logic         rdWrN,
  input  logic         dStrobe,
  output ctrl_strobe_t strb,
  output logic         busOe
);
  logic statusReadNow;
  logic armedQ;

  assign statusReadNow = !csN && regSel && rdWrN;

  // Remember that the previous cycle was a strobed status read
  always_ff @(posedge clk) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= dStrobe && statusReadNow;
  end

  always_comb begin
    strb.clearFlags  = armedQ && !dStrobe;
    strb.driveStatus = statusReadNow;
    busOe            = !csN && rdWrN;
  end

  // R6
  clear_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearFlags |-> $past(dStrobe));
  // R9
  no_clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !dStrobe) |=> !strb.clearFlags);
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int  DATA_W     = 4,
  parameter bit  STEER_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic              burstMode,
  input  logic              evtPauseDone,
  input  logic              evtDigitLatched,
  input  logic              evtToneOn,
  input  logic              evtToneOff,
  output logic [DATA_W-1:0] busData,
  output logic              irqPending
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic txRdyQ, rxFulQ, irqQ, steerQ;
  logic setTx;
  logic [STAT_W-1:0] statWord;

  assign setTx = evtPauseDone && burstMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRdyQ <= 1'b0;
      rxFulQ <= 1'b0;
      irqQ   <= 1'b0;
      steerQ <= STEER_INIT;
    end else begin
      // transmit ready: only exists in burst mode; set beats clear
      if (!burstMode)            txRdyQ <= 1'b0;
      else if (setTx)            txRdyQ <= 1'b1;
      else if (strb.clearFlags)  txRdyQ <= 1'b0;

      if (evtDigitLatched)       rxFulQ <= 1'b1;
      else if (strb.clearFlags)  rxFulQ <= 1'b0;

      if (setTx || evtDigitLatched) irqQ <= 1'b1;
      else if (strb.clearFlags)     irqQ <= 1'b0;

      // steering level: tone absence sets, tone presence clears
      if (evtToneOff && !evtToneOn)      steerQ <= 1'b1;
      else if (evtToneOn && !evtToneOff) steerQ <= 1'b0;
    end
  end

  always_comb begin
    statWord            = '0;
    statWord[IRQ_BIT]   = irqQ;
    statWord[TXRDY_BIT] = txRdyQ;
    statWord[RXFUL_BIT] = rxFulQ;
    statWord[STEER_BIT] = steerQ;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign busData = strb.driveStatus ? {{PAD_W{1'b0}}, statWord} : '0;
    end else begin : g_exact
      assign busData = strb.driveStatus ? statWord : '0;
    end
  endgenerate

  assign irqPending = irqQ;

  // R2
  rx_sets_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtDigitLatched |=> (rxFulQ && irqQ));
  // R3
  tx_burst_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtPauseDone && burstMode) |=> (txRdyQ && irqQ));
  // R4
  tx_burst_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !burstMode |=> !txRdyQ);
  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearFlags && !evtDigitLatched && !evtPauseDone) |=> (!irqQ && !rxFulQ && !txRdyQ));
  // R8
  steer_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!evtToneOn && !evtToneOff) |=> $stable(steerQ));
  // R8
  steer_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtToneOn && !evtToneOff) |=> !steerQ);
endmodule

// File: rtl/tone_status_irq.sv
module tone_status_irq
  import tsi_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter bit STEER_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              regSel,
  input  logic              rdWrN,
  input  logic              dStrobe,
  input  logic              burstMode,
  input  logic              evtPauseDone,
  input  logic              evtDigitLatched,
  input  logic              evtToneOn,
  input  logic              evtToneOff,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              irqN
);
  ctrl_strobe_t strb;
  logic         irqPending;

  tsi_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .regSel  (regSel),
    .rdWrN   (rdWrN),
    .dStrobe (dStrobe),
    .strb    (strb),
    .busOe   (busOe)
  );

  tsi_datapath #(
    .DATA_W     (DATA_W),
    .STEER_INIT (STEER_INIT)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .burstMode       (burstMode),
    .evtPauseDone    (evtPauseDone),
    .evtDigitLatched (evtDigitLatched),
    .evtToneOn       (evtToneOn),
    .evtToneOff      (evtToneOff),
    .busData         (busOut),
    .irqPending      (irqPending)
  );

  assign irqN = !irqPending;

  // R1
  irq_idle_reset_chk: assert property (@(posedge clk)
    !rstN |=> irqN);
endmodule

// File: tb/tone_status_irq_tb.sv
`timescale 1ns/1ps
module tone_status_irq_tb;
  logic clk = 1'b0;
  logic rstN;
  logic csN, regSel, rdWrN, dStrobe, burstMode;
  logic evtPauseDone, evtDigitLatched, evtToneOn, evtToneOff;
  logic [3:0] busOut;
  logic busOe, irqN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tone_status_irq u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .regSel(regSel), .rdWrN(rdWrN),
    .dStrobe(dStrobe), .burstMode(burstMode), .evtPauseDone(evtPauseDone),
    .evtDigitLatched(evtDigitLatched), .evtToneOn(evtToneOn),
    .evtToneOff(evtToneOff), .busOut(busOut), .busOe(busOe), .irqN(irqN)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleBus();
    csN = 1'b1; regSel = 1'b0; rdWrN = 1'b1; dStrobe = 1'b0;
  endtask

  // Full status read; returns the word seen mid-strobe, checks stability (R5)
  task automatic readStatus(output logic [3:0] seen);
    logic [3:0] first;
    @(negedge clk);
    csN = 1'b0; regSel = 1'b1; rdWrN = 1'b1; dStrobe = 1'b1;
    #1;
    first = busOut;
    chk("R5 oe during read", {7'd0, busOe}, 8'd1);
    @(negedge clk);
    @(negedge clk);
    seen = busOut;
    chk("R5 stable during strobe", {4'd0, seen}, {4'd0, first});
    idleBus();
    @(negedge clk);
  endtask

  // Peek status without clearing (strobe never raised)
  task automatic peek(output logic [3:0] val);
    csN = 1'b0; regSel = 1'b1; rdWrN = 1'b1; dStrobe = 1'b0;
    #1;
    val = busOut;
    idleBus();
    #1;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evtPauseDone = 1'b1;
      1: evtDigitLatched = 1'b1;
      2: evtToneOn = 1'b1;
      3: evtToneOff = 1'b1;
      default: begin evtToneOn = 1'b1; evtToneOff = 1'b1; end
    endcase
    @(negedge clk);
    evtPauseDone = 0; evtDigitLatched = 0; evtToneOn = 0; evtToneOff = 0;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    peek(v);
    chk("R1 reset status", {4'd0, v}, 8'h08);
    chk("R1 reset irqN", {7'd0, irqN}, 8'd1);
  endtask

  task automatic t_rx();
    logic [3:0] v;
    pulse(1);
    peek(v);
    chk("R2 rx sets bits", {4'd0, v}, 8'h0D);
    chk("R2 irqN low", {7'd0, irqN}, 8'd0);
    readStatus(v);
    chk("R5 read value", {4'd0, v}, 8'h0D);
    peek(v);
    chk("R6 cleared after read", {4'd0, v}, 8'h08);
    chk("R6 irqN released", {7'd0, irqN}, 8'd1);
  endtask

  task automatic t_txBurst();
    logic [3:0] v;
    burstMode = 1'b1;
    pulse(0);
    peek(v);
    chk("R3 burst pause sets", {4'd0, v}, 8'h0B);
    chk("R3 irqN low", {7'd0, irqN}, 8'd0);
    readStatus(v);
    peek(v);
    chk("R6 tx cleared by read", {4'd0, v}, 8'h08);
  endtask

  task automatic t_txNoBurst();
    logic [3:0] v;
    burstMode = 1'b0;
    pulse(0);
    peek(v);
    chk("R3 no burst ignored", {4'd0, v}, 8'h08);
    chk("R3 irqN stays high", {7'd0, irqN}, 8'd1);
  endtask

  task automatic t_burstOff();
    logic [3:0] v;
    burstMode = 1'b1;
    pulse(0);
    @(negedge clk);
    burstMode = 1'b0;
    @(negedge clk);
    peek(v);
    chk("R4 tx bit dropped", {7'd0, v[1]}, 8'd0);
    readStatus(v);
  endtask

  task automatic t_setWins();
    logic [3:0] v;
    @(negedge clk);
    csN = 1'b0; regSel = 1'b1; rdWrN = 1'b1; dStrobe = 1'b1;
    @(negedge clk);
    idleBus();
    evtDigitLatched = 1'b1;
    @(negedge clk);
    evtDigitLatched = 1'b0;
    peek(v);
    chk("R7 set beats clear", {4'd0, v}, 8'h0D);
    readStatus(v);
  endtask

  task automatic t_steer();
    logic [3:0] v;
    readStatus(v);
    chk("R8 steer survives read", {4'd0, v}, 8'h08);
    chk("R8 steer no irq", {7'd0, irqN}, 8'd1);
    pulse(2);
    peek(v);
    chk("R8 tone on clears", {4'd0, v}, 8'h00);
    pulse(4);
    peek(v);
    chk("R8 both holds", {4'd0, v}, 8'h00);
    pulse(3);
    peek(v);
    chk("R8 tone off sets", {4'd0, v}, 8'h08);
  endtask

  task automatic t_noSelect();
    logic [3:0] v;
    pulse(1);
    // R9: strobe without chip select
    @(negedge clk);
    csN = 1'b1; regSel = 1'b1; rdWrN = 1'b1; dStrobe = 1'b1;
    #1;
    chk("R9 oe low when deselected", {7'd0, busOe}, 8'd0);
    @(negedge clk); dStrobe = 1'b0;
    @(negedge clk);
    peek(v);
    chk("R9 no clear deselected", {4'd0, v}, 8'h0D);
    // R10: other register read
    @(negedge clk);
    csN = 1'b0; regSel = 1'b0; rdWrN = 1'b1; dStrobe = 1'b1;
    #1;
    chk("R10 other register zero", {4'd0, busOut}, 8'h00);
    @(negedge clk); dStrobe = 1'b0;
    @(negedge clk);
    // R10: write cycle to status address
    csN = 1'b0; regSel = 1'b1; rdWrN = 1'b0; dStrobe = 1'b1;
    @(negedge clk); dStrobe = 1'b0;
    @(negedge clk);
    idleBus();
    peek(v);
    chk("R10 no clear on other access", {4'd0, v}, 8'h0D);
    chk("R10 irqN still low", {7'd0, irqN}, 8'd0);
    readStatus(v);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; idleBus(); burstMode = 1'b0;
    evtPauseDone = 0; evtDigitLatched = 0; evtToneOn = 0; evtToneOff = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx();
    t_txBurst();
    t_txNoBurst();
    t_burstOff();
    t_setWins();
    t_steer();
    t_noSelect();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule